// File: doc/BRIEF.md
# Check-to-Bit Message Reconstructor

This block sits beside the bit-node unit of a serial sum-product decoder for low-density parity-check codes. Bit nodes are processed one per cycle, and each has DC edges. For each of its check nodes, the block receives that check's accumulated totals from the previous iteration: a sign parity and a sum of transformed magnitudes. It also holds, in an internal row buffer, the contribution this bit node itself made to each of those totals one iteration earlier. A message from a check to this bit must leave out the bit's own contribution. The block gets it by taking that contribution back out: the sign is the XOR of the parity with the own sign, and the magnitude is the transform of the clamped difference between the sum and the own transformed magnitude. The result is converted to two's complement for the bit-node adders.

Every accepted cycle pushes the current iteration's row of (sign, transformed magnitude) pairs for the bit node. In the same cycle the buffer gives back the row that the same bit node pushed one full pass earlier. A build-time parameter selects one of two row layouts. In the standalone layout a row holds one pair for each edge. In the detector-concatenated layout all outgoing messages of a bit equal its a priori value, so a row holds a single pair that serves every edge. The block also outputs the sum of the DC rebuilt messages, which is the extrinsic value handed back to the detector in concatenated use.

Top module: `c2b_rebuild`

## Requirements
- R1: Each edge's magnitude is phi(x), where x is the clamped difference from R2. phi(0) = MAXM, and phi(x) = min(MAXM, floor(PHI_K / x)) otherwise, with MAXM = 2^MAG_W - 1.
- R2: The difference is P - rho, where P is the edge's check sum and rho is the own transformed magnitude. A negative difference is clamped to 0, and a difference above MAXM is clamped to MAXM.
- R3: Each edge's sign is the check parity bit XOR the own sign bit, where 1 means negative.
- R4: Each message is a Q = MAG_W+1 bit two's-complement value, with edge e at msg_out[e*Q +: Q]. A zero magnitude always gives all zeros, so the pattern with only the top bit set never appears.
- R5: In standalone layout (CAT_MODE=0) a row holds DC pairs. Pair e sits at bits [e*Q +: Q], with its sign in the top bit and rho in the low MAG_W bits, and it serves edge e.
- R6: In concatenated layout (CAT_MODE=1) a row is a single Q-bit pair with the same field order, and that pair serves all DC edges.
- R7: The row used in a cycle is the one pushed exactly N_BITS accepted cycles earlier. Cycles with in_valid low neither push nor advance the buffer.
- R8: Until N_BITS rows have been pushed since reset, every message and ext_out is zero, because initial check messages are zero.
- R9: ext_out is the signed sum of the DC messages, EXT_W bits wide.
- R10: out_valid follows in_valid one cycle later. The outputs update only for accepted inputs and hold otherwise. Reset clears out_valid, msg_out and ext_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | One bit node presented this cycle |
| push_row | input | ROW_W | Current-iteration own pairs for this bit node |
| chk_sign | input | DC | Previous-iteration sign parity per edge's check |
| chk_sum | input | DC*SUM_W | Previous-iteration transformed-magnitude sum per edge's check |
| out_valid | output | 1 | Messages valid |
| msg_out | output | DC*Q | Rebuilt check-to-bit messages, two's complement |
| ext_out | output | EXT_W | Signed sum of the messages |

## Verification
A wrong read or write pointer in the row buffer would not be visible during the warm-up pass. It shows as soon as the first popped row is used, N_BITS accepted cycles after reset, because the messages would then be built from another bit's pairs. A wrong warm-up flag makes nonzero messages appear one pass too early, or zeros stay one pass too long. The error is visible in the cycle right after the N_BITS-th push. Sign or clamp faults corrupt the very next output, since the path from inputs to outputs is a single register.

// File: rtl/c2b_pkg.sv
package c2b_pkg;

    // Quantised reciprocal-shaped magnitude transform.
    function automatic int unsigned phi_code(int unsigned x, int unsigned k, int unsigned maxm);
        int unsigned v;
        if (x == 0) v = maxm;
        else        v = k / x;
        if (v > maxm) v = maxm;
        return v;
    endfunction

    typedef enum logic {
        LAYOUT_PER_EDGE = 1'b0,
        LAYOUT_SHARED   = 1'b1
    } row_layout_e;

endpackage

// File: rtl/c2b_row_fifo.sv
module c2b_row_fifo #(
    parameter int ROW_W = 18,
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [ROW_W-1:0] wr_row,
    output logic [ROW_W-1:0] rd_row,
    output logic             primed
);

    typedef struct packed {
        logic [DEPTH-1:0][ROW_W-1:0] mem;
        logic [PTR_W-1:0]            ptr;
        logic                        primed;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.ptr] = wr_row;
            if (st_q.ptr == PTR_W'(DEPTH - 1)) begin
                st_d.ptr    = '0;
                st_d.primed = 1'b1;
            end else begin
                st_d.ptr = st_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Read happens before the same-slot write lands: the oldest row.
    assign rd_row = st_q.mem[st_q.ptr];
    assign primed = st_q.primed;

endmodule

// File: rtl/c2b_edge.sv
module c2b_edge #(
    parameter int MAG_W = 5,
    parameter int SUM_W = 8,
    parameter int PHI_K = 64,
    localparam int Q     = MAG_W + 1,
    localparam int MAXM  = (1 << MAG_W) - 1,
    localparam int LUT_N = 1 << MAG_W,
    localparam int DW    = SUM_W + 1
) (
    input  logic             tot_sign,
    input  logic [SUM_W-1:0] tot_sum,
    input  logic             own_sign,
    input  logic [MAG_W-1:0] own_mag,
    output logic [Q-1:0]     msg
);

    logic [MAG_W-1:0] lut [LUT_N];

    for (genvar x = 0; x < LUT_N; x++) begin : g_lut
        assign lut[x] = MAG_W'(c2b_pkg::phi_code(x, PHI_K, MAXM));
    end

    logic [DW-1:0]    diff;
    logic [MAG_W-1:0] clamped;
    logic [MAG_W-1:0] mag;
    logic             neg;
    logic [Q-1:0]     mag_ext;

    always_comb begin
        diff = {1'b0, tot_sum} - {{(DW-MAG_W){1'b0}}, own_mag};
        if (diff[DW-1])
            clamped = '0;
        else if (diff[DW-2:0] > (DW-1)'(MAXM))
            clamped = MAG_W'(MAXM);
        else
            clamped = diff[MAG_W-1:0];
        mag     = lut[clamped];
        neg     = tot_sign ^ own_sign;
        mag_ext = {1'b0, mag};
        if (neg && (mag != '0)) msg = ~mag_ext + 1'b1;
        else                    msg = mag_ext;
    end

endmodule

// File: rtl/c2b_rebuild.sv
module c2b_rebuild #(
    parameter int DC       = 3,
    parameter int MAG_W    = 5,
    parameter int SUM_W    = MAG_W + $clog2(DC) + 1,
    parameter int N_BITS   = 16,
    parameter int PHI_K    = 64,
    parameter bit CAT_MODE = 1'b0,
    localparam int Q     = MAG_W + 1,
    localparam int ROW_W = CAT_MODE ? Q : DC * Q,
    localparam int EXT_W = Q + $clog2(DC)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [ROW_W-1:0]    push_row,
    input  logic [DC-1:0]       chk_sign,
    input  logic [DC*SUM_W-1:0] chk_sum,
    output logic                out_valid,
    output logic [DC*Q-1:0]     msg_out,
    output logic [EXT_W-1:0]    ext_out
);

    localparam c2b_pkg::row_layout_e LAYOUT =
        CAT_MODE ? c2b_pkg::LAYOUT_SHARED : c2b_pkg::LAYOUT_PER_EDGE;

    typedef struct packed {
        logic             valid;
        logic [DC*Q-1:0]  msgs;
        logic [EXT_W-1:0] ext;
    } out_st_t;

    out_st_t st_d, st_q;

    logic [ROW_W-1:0] pop_row;
    logic             primed;
    logic [Q-1:0]     edge_msg [DC];

    c2b_row_fifo #(.ROW_W(ROW_W), .DEPTH(N_BITS)) u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (in_valid),
        .wr_row (push_row),
        .rd_row (pop_row),
        .primed (primed)
    );

    for (genvar e = 0; e < DC; e++) begin : g_edge
        logic [Q-1:0] pair;
        if (LAYOUT == c2b_pkg::LAYOUT_SHARED) begin : g_shared
            assign pair = pop_row[Q-1:0];
        end else begin : g_own
            assign pair = pop_row[e*Q +: Q];
        end
        c2b_edge #(.MAG_W(MAG_W), .SUM_W(SUM_W), .PHI_K(PHI_K)) u_edge (
            .tot_sign (chk_sign[e]),
            .tot_sum  (chk_sum[e*SUM_W +: SUM_W]),
            .own_sign (pair[Q-1]),
            .own_mag  (pair[MAG_W-1:0]),
            .msg      (edge_msg[e])
        );
    end

    always_comb begin
        logic [EXT_W-1:0] acc;
        st_d       = st_q;
        st_d.valid = in_valid;
        acc        = '0;
        for (int e = 0; e < DC; e++)
            acc = acc + {{(EXT_W-Q){edge_msg[e][Q-1]}}, edge_msg[e]};
        if (in_valid) begin
            for (int e = 0; e < DC; e++)
                st_d.msgs[e*Q +: Q] = primed ? edge_msg[e] : '0;
            st_d.ext = primed ? acc : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign msg_out   = st_q.msgs;
    assign ext_out   = st_q.ext;

endmodule

// File: rtl/c2b_rebuild_chk.sv
module c2b_rebuild_chk #(
    parameter int DC       = 3,
    parameter int Q        = 6,
    parameter int ROW_W    = 18,
    parameter int N_BITS   = 16,
    parameter bit CAT_MODE = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [DC-1:0]    chk_sign,
    input logic [ROW_W-1:0] pop_row,
    input logic             out_valid,
    input logic [DC*Q-1:0]  msg_out
);

    localparam int CW = $clog2(N_BITS + 1);

    logic [CW-1:0] pushes_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                                     pushes_q <= '0;
        else if (in_valid && pushes_q != CW'(N_BITS))   pushes_q <= pushes_q + 1'b1;
    end

    p_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(msg_out)));

    p_warm_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pushes_q != CW'(N_BITS)) |=> (msg_out == '0));

    for (genvar e = 0; e < DC; e++) begin : g_e
        logic own_s;
        if (CAT_MODE) begin : g_c
            assign own_s = pop_row[Q-1];
        end else begin : g_s
            assign own_s = pop_row[e*Q + Q-1];
        end

        p_no_negzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (msg_out[e*Q +: Q] != {1'b1, {(Q-1){1'b0}}}));

        p_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && pushes_q == CW'(N_BITS)) |=>
            ((msg_out[e*Q +: Q] == '0) ||
             (msg_out[e*Q + Q-1] == $past(chk_sign[e] ^ own_s))));
    end

endmodule

bind c2b_rebuild c2b_rebuild_chk #(
    .DC(DC), .Q(Q), .ROW_W(ROW_W), .N_BITS(N_BITS), .CAT_MODE(CAT_MODE)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .chk_sign  (chk_sign),
    .pop_row   (pop_row),
    .out_valid (out_valid),
    .msg_out   (msg_out)
);

// File: tb/c2b_rebuild_tb.sv
`timescale 1ns/1ps
module c2b_rebuild_tb_top;

    localparam int DC    = 3;
    localparam int MAG_W = 5;
    localparam int SUM_W = MAG_W + $clog2(DC) + 1;
    localparam int NB    = 8;
    localparam int PK    = 64;
    localparam int Q     = MAG_W + 1;
    localparam int EXT_W = Q + $clog2(DC);
    localparam int MAXM  = (1 << MAG_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [DC*Q-1:0]     row_sa = '0;
    logic [Q-1:0]        row_cat = '0;
    logic [DC-1:0]       chk_sign = '0;
    logic [DC*SUM_W-1:0] chk_sum = '0;

    logic                v_sa, v_cat;
    logic [DC*Q-1:0]     m_sa, m_cat;
    logic [EXT_W-1:0]    x_sa, x_cat;

    always #2 clk = ~clk;

    c2b_rebuild #(.DC(DC), .MAG_W(MAG_W), .N_BITS(NB), .PHI_K(PK), .CAT_MODE(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .push_row(row_sa),
        .chk_sign(chk_sign), .chk_sum(chk_sum),
        .out_valid(v_sa), .msg_out(m_sa), .ext_out(x_sa));

    c2b_rebuild #(.DC(DC), .MAG_W(MAG_W), .N_BITS(NB), .PHI_K(PK), .CAT_MODE(1'b1)) dut_cat_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .push_row(row_cat),
        .chk_sign(chk_sign), .chk_sum(chk_sum),
        .out_valid(v_cat), .msg_out(m_cat), .ext_out(x_cat));

    int n_chk = 0;
    int n_bad = 0;

    logic [DC*Q-1:0] q_sa [$];
    logic [Q-1:0]    q_cat [$];
    int  e_sa [DC];
    int  e_cat [DC];
    int  ex_sa = 0, ex_cat = 0;
    bit  e_valid = 0;

    function automatic int phi_ref(int x);
        int v;
        v = (x == 0) ? MAXM : PK / x;
        return (v > MAXM) ? MAXM : v;
    endfunction

    // R1 R2 R3: sign = S^sigma, magnitude = phi(clamp(P - rho))
    function automatic int edge_ref(bit s, int p, bit sg, int rho);
        int d, m;
        d = p - rho;
        if (d < 0) d = 0;
        if (d > MAXM) d = MAXM;
        m = phi_ref(d);
        return (s ^ sg) ? -m : m;
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare(string req);
        check("R10 valid", int'(v_sa), int'(e_valid));
        check("R10 valid cat", int'(v_cat), int'(e_valid));
        for (int e = 0; e < DC; e++) begin
            check({req, " R5 msg"}, int'($signed(m_sa[e*Q +: Q])), e_sa[e]);
            check({req, " R6 msg"}, int'($signed(m_cat[e*Q +: Q])), e_cat[e]);
        end
        check({req, " R9 ext"}, int'($signed(x_sa)), ex_sa);
        check({req, " R9 ext cat"}, int'($signed(x_cat)), ex_cat);
    endtask

    // Drive at a falling edge, update model, compare at the next falling edge. R7
    task automatic step(bit v, logic [DC-1:0] s, logic [DC*SUM_W-1:0] p,
                        logic [DC*Q-1:0] rs, logic [Q-1:0] rc, string req);
        in_valid = v; chk_sign = s; chk_sum = p; row_sa = rs; row_cat = rc;
        e_valid = v;
        if (v) begin
            if (q_sa.size() == NB) begin
                logic [DC*Q-1:0] ps;
                logic [Q-1:0]    pc;
                ps = q_sa.pop_front();
                pc = q_cat.pop_front();
                ex_sa = 0; ex_cat = 0;
                for (int e = 0; e < DC; e++) begin
                    e_sa[e]  = edge_ref(s[e], int'(p[e*SUM_W +: SUM_W]),
                                        ps[e*Q+Q-1], int'(ps[e*Q +: MAG_W]));
                    e_cat[e] = edge_ref(s[e], int'(p[e*SUM_W +: SUM_W]),
                                        pc[Q-1], int'(pc[MAG_W-1:0]));
                    ex_sa  += e_sa[e];
                    ex_cat += e_cat[e];
                end
            end else begin
                for (int e = 0; e < DC; e++) begin e_sa[e] = 0; e_cat[e] = 0; end
                ex_sa = 0; ex_cat = 0;
            end
            q_sa.push_back(rs);
            q_cat.push_back(rc);
        end
        @(negedge clk);
        compare(req);
    endtask

    function automatic logic [DC*SUM_W-1:0] rnd_sum();
        logic [DC*SUM_W-1:0] r;
        for (int e = 0; e < DC; e++) r[e*SUM_W +: SUM_W] = SUM_W'($urandom);
        return r;
    endfunction

    initial begin
        for (int e = 0; e < DC; e++) begin e_sa[e] = 0; e_cat[e] = 0; end
        repeat (3) @(negedge clk);
        compare("R10 reset");
        rst_n = 1'b1;

        // R8 warm-up pass: outputs stay zero
        for (int i = 0; i < NB; i++)
            step(1'b1, DC'($urandom), rnd_sum(), (DC*Q)'($urandom), Q'($urandom), "R8");

        // R2 negative: push rho = MAXM rows, later pop against P = 0
        for (int i = 0; i < NB; i++) begin
            logic [DC*Q-1:0] r;
            for (int e = 0; e < DC; e++) r[e*Q +: Q] = {1'($urandom), MAG_W'(MAXM)};
            step(1'b1, DC'($urandom), rnd_sum(), r, {1'($urandom), MAG_W'(MAXM)}, "R1 R3 R4");
        end
        for (int i = 0; i < NB; i++) begin
            logic [DC*Q-1:0] r;
            for (int e = 0; e < DC; e++) r[e*Q +: Q] = {1'($urandom), MAG_W'(0)};
            step(1'b1, DC'($urandom), '0, r, {1'($urandom), MAG_W'(0)}, "R2 low");
        end
        // R2 upper clamp: rho = 0 rows popped against full-scale P
        for (int i = 0; i < NB; i++)
            step(1'b1, DC'($urandom), '1, (DC*Q)'($urandom), Q'($urandom), "R2 high");

        // R7 R10: random traffic with idle gaps
        for (int i = 0; i < 300; i++) begin
            bit v;
            v = ($urandom % 5) != 0;
            step(v, DC'($urandom), rnd_sum(), (DC*Q)'($urandom), Q'($urandom), "R7 R3 R1");
        end
        step(1'b0, '0, '0, '0, '0, "R10 idle");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule